// File: doc/BRIEF.md
# Timer clock source prescaler

This block is the clock front end of one timer channel. It holds a small control register with three fields: a source select, a division select and a debug-run flag. From four clock-enable streams it picks one: internal oscillator, low-speed oscillator, high-speed oscillator or external clock. All four streams are single-cycle enable pulses on one system clock. The block divides the chosen stream by a power of two and presents the result as a one-cycle counter-clock enable. The timer counter that follows it uses this enable.

The set of division ratios depends on the source. The internal and high-speed sources accept every division select value. The low-speed source is limited to a parameter cap, and any value above the cap runs at 1/1. The external source always runs at 1/1. A debug-halt input stops the counter clock unless the debug-run flag is set. While the output is stopped, the divider holds its count. Any register write restarts the divider from zero.

Top module: `tmr_clkfront`

## Requirements
- R1: Register fields are laid out as follows: source select in bits 1:0, division select in bits 4+DIV_W-1:4, and debug-run in bit DBG_BIT (8). With the bench's DIV_W=3, a write of 0xFFFF reads back as 0x0173. Every other bit reads as zero and ignores writes.
- R2: After reset the register reads 0x0000 and cnt_en is low.
- R3: Source select 0 uses src_en[0] (internal), 1 uses src_en[1] (low-speed), 2 uses src_en[2] (high-speed) and 3 uses src_en[3] (external). The three unselected enables have no effect on cnt_en.
- R4: For sources 0 and 2 with division select k, cnt_en is high for exactly one cycle after every 2^k-th selected pulse. That cycle is the one after the clock edge that samples the pulse.
- R5: For source 1, division select values k up to LS_CAP give 1/2^k. Values above LS_CAP give 1/1.
- R6: For source 3 every selected pulse produces a cnt_en pulse, whatever the division select holds.
- R7: While dbg_halt is high and debug-run is 0, cnt_en stays low. Selected pulses in that time are not counted, so division resumes in phase when the halt ends.
- R8: While debug-run is 1, dbg_halt has no effect on cnt_en.
- R9: Any register write clears the divider, and a selected pulse in the write cycle is not counted. cnt_en is low in the cycle after a write. The first output then follows the 2^k-th selected pulse after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data |
| src_en | input | 4 | Per-source clock-enable pulses: internal, low-speed, high-speed, external |
| dbg_halt | input | 1 | System halted for debug |
| cnt_en | output | 1 | Counter-clock enable pulse |

## Verification
The bench builds the block with DIV_W=3 and LS_CAP=4. Under these settings the longest period is 128 source pulses. This makes it cheap to sweep every source against every division select value, including the low-speed values above the cap. Each combination is run without halt, with halt and debug-run clear, and with halt and debug-run set. The selected enable is driven in an irregular pattern and the unselected enables in the opposite pattern. An arithmetic pulse-count model predicts cnt_en in every cycle.

// File: rtl/tmr_clkfront_pkg.sv
package tmr_clkfront_pkg;
   typedef enum logic [1:0] {
      SRC_INT  = 2'd0,
      SRC_LOW  = 2'd1,
      SRC_HIGH = 2'd2,
      SRC_EXT  = 2'd3
   } src_e;

   localparam int unsigned NSRC = 4;
endpackage

// File: rtl/tmr_cf_regs.sv
module tmr_cf_regs
   import tmr_clkfront_pkg::*;
#(
   parameter int unsigned REG_W   = 16,
   parameter int unsigned DIV_W   = 4,
   parameter int unsigned DBG_BIT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output src_e             src_sel,
   output logic [DIV_W-1:0] div_sel,
   output logic             dbg_run
);
   localparam int unsigned DIV_LSB = 4;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_sel <= SRC_INT;
         div_sel <= '0;
         dbg_run <= 1'b0;
      end else if (wr) begin
         src_sel <= src_e'(wdata[1:0]);
         div_sel <= wdata[DIV_LSB +: DIV_W];
         dbg_run <= wdata[DBG_BIT];
      end
   end

   always_comb begin
      rdata                   = '0;
      rdata[1:0]              = src_sel;
      rdata[DIV_LSB +: DIV_W] = div_sel;
      rdata[DBG_BIT]          = dbg_run;
   end
endmodule

// File: rtl/tmr_cf_srcsel.sv
module tmr_cf_srcsel
   import tmr_clkfront_pkg::*;
(
   input  logic [NSRC-1:0] src_en,
   input  src_e            sel,
   output logic            sel_en
);
   logic [NSRC-1:0] hit;

   for (genvar i = 0; i < NSRC; i++) begin : g_leg
      assign hit[i] = src_en[i] && (sel == src_e'(i));
   end

   assign sel_en = |hit;
endmodule

// File: rtl/tmr_cf_divider.sv
module tmr_cf_divider
   import tmr_clkfront_pkg::*;
#(
   parameter int unsigned DIV_W  = 4,
   parameter int unsigned LS_CAP = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  src_e             src_sel,
   input  logic [DIV_W-1:0] div_sel,
   output logic             pulse
);
   localparam int unsigned CNT_W = (1 << DIV_W) - 1;

   logic [DIV_W-1:0] k_eff;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;
   logic             wrap;

   always_comb begin
      unique case (src_sel)
         SRC_LOW: k_eff = (32'(div_sel) <= LS_CAP) ? div_sel : '0;
         SRC_EXT: k_eff = '0;
         default: k_eff = div_sel;
      endcase
   end

   assign mask = ~({CNT_W{1'b1}} << k_eff);
   assign wrap = (cnt & mask) == mask;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else begin
         pulse <= step && wrap;
         if (step) cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/tmr_clkfront.sv
module tmr_clkfront
   import tmr_clkfront_pkg::*;
#(
   parameter int unsigned REG_W   = 16,
   parameter int unsigned DIV_W   = 4,
   parameter int unsigned LS_CAP  = 8,
   parameter int unsigned DBG_BIT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic [3:0]       src_en,
   input  logic             dbg_halt,
   output logic             cnt_en
);
   if (DIV_W < 1 || DIV_W > 5) begin : g_bad_div
      $error("DIV_W out of range");
   end
   if (LS_CAP >= (1 << DIV_W)) begin : g_bad_cap
      $error("LS_CAP must be below 2**DIV_W");
   end
   if (DBG_BIT < 4 + DIV_W || DBG_BIT >= REG_W) begin : g_bad_dbg
      $error("DBG_BIT overlaps a field or lies outside the register");
   end

   src_e             src_sel;
   logic [DIV_W-1:0] div_sel;
   logic             dbg_run;
   logic             sel_en;
   logic             step;

   tmr_cf_regs #(.REG_W(REG_W), .DIV_W(DIV_W), .DBG_BIT(DBG_BIT)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .src_sel (src_sel),
      .div_sel (div_sel),
      .dbg_run (dbg_run)
   );

   tmr_cf_srcsel u_sel (
      .src_en (src_en),
      .sel    (src_sel),
      .sel_en (sel_en)
   );

   assign step = sel_en && (!dbg_halt || dbg_run);

   tmr_cf_divider #(.DIV_W(DIV_W), .LS_CAP(LS_CAP)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (reg_wr),
      .step    (step),
      .src_sel (src_sel),
      .div_sel (div_sel),
      .pulse   (cnt_en)
   );
endmodule

// File: rtl/tmr_clkfront_chk.sv
module tmr_clkfront_chk #(
   parameter int unsigned REG_W   = 16,
   parameter int unsigned DIV_W   = 4,
   parameter int unsigned LS_CAP  = 8,
   parameter int unsigned DBG_BIT = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic [3:0]       src_en,
   input logic             dbg_halt,
   input logic             cnt_en
);
   logic [1:0]       cur_src;
   logic [DIV_W-1:0] cur_div;
   logic             cur_run;
   logic             cur_en;
   logic             blocked;

   assign cur_src = reg_rdata[1:0];
   assign cur_div = reg_rdata[4 +: DIV_W];
   assign cur_run = reg_rdata[DBG_BIT];
   assign cur_en  = src_en[cur_src];
   assign blocked = dbg_halt && !cur_run;

   // R3
   pulse_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |-> $past(cur_en));

   // R9
   write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_wr) |-> !cnt_en);

   // R7
   halt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(blocked) |-> !cnt_en);

   // R6
   ext_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cur_src) == 2'd3 && $past(cur_en) && !$past(reg_wr) && !$past(blocked))
      |-> cnt_en);

   // R5
   low_capped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cur_src) == 2'd1 && 32'($past(cur_div)) > LS_CAP && $past(cur_en)
       && !$past(reg_wr) && !$past(blocked)) |-> cnt_en);
endmodule

bind tmr_clkfront tmr_clkfront_chk #(
   .REG_W(REG_W), .DIV_W(DIV_W), .LS_CAP(LS_CAP), .DBG_BIT(DBG_BIT)
) u_chk (.*);

// File: tb/tmr_clkfront_test.sv
`timescale 1ns/1ps
module tmr_clkfront_test;
   localparam int unsigned DIV_W  = 3;
   localparam int unsigned LS_CAP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [3:0]  src_en = '0;
   logic        dbg_halt = 1'b0;
   logic        cnt_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tmr_clkfront #(.DIV_W(DIV_W), .LS_CAP(LS_CAP)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .src_en(src_en), .dbg_halt(dbg_halt), .cnt_en(cnt_en)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int keff(input int src, input int dv);
      if (src == 3) return 0;
      if (src == 1 && dv > LS_CAP) return 0;
      return dv;
   endfunction

   task automatic wr_reg(input logic [15:0] v);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = v;
      src_en = 4'hF;
      @(negedge clk);
      reg_wr = 1'b0;
      src_en = '0;
      check("R9", int'(cnt_en), 0);
   endtask

   task automatic sweep(input int mode, input int src, input int dv);
      int period = 1 << keff(src, dv);
      int n = 0;
      bit run = (mode == 2);
      wr_reg({7'd0, run, 1'b0, 3'(dv), 2'b00, 2'(src)});
      for (int i = 0; i < 5 * period + 8; i++) begin
         bit pat = (i % 3) != 1;
         bit halt = (mode != 0) && ((i % 5) < 2);
         bit step = pat && (!halt || run);
         bit exp;
         for (int s = 0; s < 4; s++) src_en[s] = (s == src) ? pat : !pat;
         dbg_halt = halt;
         if (step) n++;
         exp = step && (n % period == 0);
         @(negedge clk);
         if (src == 3) check("R6", int'(cnt_en), int'(exp));
         else if (src == 1) check(dv > LS_CAP ? "R5" : "R3", int'(cnt_en), int'(exp));
         else if (mode == 1) check("R7", int'(cnt_en), int'(exp));
         else if (mode == 2) check("R8", int'(cnt_en), int'(exp));
         else check("R4", int'(cnt_en), int'(exp));
      end
      src_en = '0;
      dbg_halt = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R2", int'(reg_rdata), 0);
      check("R2", int'(cnt_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2", int'(reg_rdata), 0);

      wr_reg(16'hFFFF);
      check("R1", int'(reg_rdata), 16'h0173);
      wr_reg(16'h0000);
      check("R1", int'(reg_rdata), 16'h0000);

      for (int mode = 0; mode < 3; mode++)
         for (int src = 0; src < 4; src++)
            for (int dv = 0; dv < (1 << DIV_W); dv++)
               sweep(mode, src, dv);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule